// File: doc/BRIEF.md
# Device Reset Sequencer with Retry

This block brings a multi-domain transceiver out of power-on reset on command. A start pulse pulls the active-low device reset pin low for a minimum hold time. The sequencer then releases the pin and waits two further periods. The first lets the device's internal clock synthesizer timer run out. The second lets the serial link settle. After that it samples the device's status lines and decides whether the reset worked.

A good reset needs three things. The reset-timer-expired flag must be set, and the PLL-settled flag must be set. Every monitored loss-of-lock bit must be clear, except the bits named in a mask, since those lines lock only later in bring-up. The status lines cross from the device's clock domain, so each one passes through a two-flop synchronizer before it is used.

A failed check starts a new hold phase at once. After the last allowed attempt, the block reports the outcome with a one-cycle done pulse and a fail flag. Every phase length is given in microseconds and turned into clock cycles from the clock frequency parameter.

Top module: `rst_sequencer`

## Requirements
- R1: After reset the pin output `resetN` is high, `done` is 0 and `fail` is 0, and nothing happens until a start pulse arrives.
- R2: A start pulse drives `resetN` low for exactly HOLD_CYC = ceil(CLK_KHZ*HOLD_US/1000) cycles, beginning at the clock edge that samples the start pulse. HOLD_US defaults to 4000.
- R3: After release the block waits SETTLE_CYC cycles (15000 us by default), then LINK_CYC cycles (200 us by default), then spends one cycle checking. For a single attempt, `done` rises HOLD_CYC+SETTLE_CYC+LINK_CYC+1 edges after the start edge, and `resetN` is high while `done` is high.
- R4: An attempt succeeds only when `timerExpired` is 1, `pllSettled` is 1, and `lossOfLock & ~IGNORE_MASK` is all zero. These are the synchronized values at the check cycle.
- R5: Loss-of-lock bits set in IGNORE_MASK have no effect on the result. The default mask ignores bit 3 of the 4-bit vector.
- R6: A failed check starts the next attempt immediately with a fresh hold phase. The block makes at most MAX_TRIES attempts (default 3), each taking the same number of cycles.
- R7: If every attempt fails, `done` rises with `fail` = 1. If any attempt passes, the sequence stops at that attempt with `fail` = 0.
- R8: `done` is high for exactly one cycle. `fail` is valid in that cycle and holds its value until the next accepted start pulse.
- R9: A start pulse that arrives while a sequence is running has no effect on the phase timing or on the outcome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock at CLK_KHZ kHz |
| rstN | input | 1 | Asynchronous active-low block reset |
| start | input | 1 | One-cycle request to begin a reset sequence |
| timerExpired | input | 1 | Device status: internal reset timer has run out |
| pllSettled | input | 1 | Device status: clock synthesizer PLLs are settled |
| lossOfLock | input | LOL_W | Device status: one loss-of-lock bit per monitored clock domain |
| resetN | output | 1 | Active-low reset pin driven to the device |
| done | output | 1 | One-cycle pulse when the sequence has finished |
| fail | output | 1 | Outcome flag, 1 when every attempt failed |

## Verification
A wrong internal state appears at the ports in two ways. A miscounting timer or a wrong phase order shifts the edge where `resetN` rises, or shifts the `done` pulse, by at least one cycle. The bench measures both against cycle counts it computes from the microsecond parameters. A bad status decision or a bad attempt counter changes the number of low-pulse episodes on `resetN` and the value of `fail`. These show up by the end of the sequence, at most three attempts after the start edge. Random status patterns per attempt are mixed with directed cases: an ignored bit set, a pass on the second attempt, total failure, and a start pulse during a run.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_SETTLE,
    ST_LINK,
    ST_CHECK
  } seqState_e;

  typedef enum logic [1:0] {
    LD_HOLD,
    LD_SETTLE,
    LD_LINK
  } loadSel_e;

  // Strobes sent from the control FSM to the datapath
  typedef struct packed {
    logic     timerLoad;
    loadSel_e loadSel;
    logic     triesClr;
    logic     triesInc;
  } seqStrobe_t;

endpackage

// File: rtl/rst_seq_datapath.sv
module rst_seq_datapath
  import rst_seq_pkg::*;
#(
  parameter int unsigned LOL_W = 4,
  parameter logic [LOL_W-1:0] IGNORE_MASK = 4'b1000,
  parameter int unsigned MAX_TRIES = 3,
  parameter int unsigned CNT_W = 20,
  parameter longint HOLD_CYC = 40,
  parameter longint SETTLE_CYC = 150,
  parameter longint LINK_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             timerExpired,
  input  logic             pllSettled,
  input  logic [LOL_W-1:0] lossOfLock,
  output logic             timerZero,
  output logic             statusOk,
  output logic             lastTry
);

  localparam int unsigned SYNC_W = LOL_W + 2;
  localparam int unsigned TRY_W  = $clog2(MAX_TRIES + 1);
  localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] LINK_LD   = CNT_W'(LINK_CYC - 1);

  // Two-flop synchronizer for all status lines
  logic [SYNC_W-1:0] syncA, syncB;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= {timerExpired, pllSettled, lossOfLock};
      syncB <= syncA;
    end
  end

  logic [LOL_W-1:0] lolWatched;
  assign lolWatched = syncB[LOL_W-1:0] & ~IGNORE_MASK;
  assign statusOk   = syncB[LOL_W+1] & syncB[LOL_W] & ~|lolWatched;

  // Phase timer, counts down to zero
  logic [CNT_W-1:0] cnt, loadVal;
  always_comb begin
    case (strobe.loadSel)
      LD_SETTLE: loadVal = SETTLE_LD;
      LD_LINK:   loadVal = LINK_LD;
      default:   loadVal = HOLD_LD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (strobe.timerLoad) cnt <= loadVal;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end
  assign timerZero = (cnt == '0);

  // Attempt counter
  logic [TRY_W-1:0] tries;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tries <= '0;
    else if (strobe.triesClr) tries <= TRY_W'(1);
    else if (strobe.triesInc) tries <= tries + 1'b1;
  end
  assign lastTry = (tries >= TRY_W'(MAX_TRIES));

  AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    tries <= TRY_W'(MAX_TRIES)); // R6

  AST_TRIES_ONLY_AFTER_FAIL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.triesInc |-> !statusOk); // R6

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       timerZero,
  input  logic       statusOk,
  input  logic       lastTry,
  output seqStrobe_t strobe,
  output logic       resetN,
  output logic       done,
  output logic       fail
);

  seqState_e state, stateNext;
  logic finishNow, finalFail;
  logic resetNQ, doneQ, failQ;

  always_comb begin
    stateNext      = state;
    strobe         = '0;
    strobe.loadSel = LD_HOLD;
    finishNow      = 1'b0;
    finalFail      = 1'b0;
    case (state)
      ST_IDLE: if (start) begin
        stateNext        = ST_HOLD;
        strobe.timerLoad = 1'b1;
        strobe.loadSel   = LD_HOLD;
        strobe.triesClr  = 1'b1;
      end
      ST_HOLD: if (timerZero) begin
        stateNext        = ST_SETTLE;
        strobe.timerLoad = 1'b1;
        strobe.loadSel   = LD_SETTLE;
      end
      ST_SETTLE: if (timerZero) begin
        stateNext        = ST_LINK;
        strobe.timerLoad = 1'b1;
        strobe.loadSel   = LD_LINK;
      end
      ST_LINK: if (timerZero) stateNext = ST_CHECK;
      ST_CHECK: begin
        if (statusOk) begin
          finishNow = 1'b1;
        end else if (!lastTry) begin
          stateNext        = ST_HOLD;
          strobe.timerLoad = 1'b1;
          strobe.loadSel   = LD_HOLD;
          strobe.triesInc  = 1'b1;
        end else begin
          finishNow = 1'b1;
          finalFail = 1'b1;
        end
        if (finishNow) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      resetNQ <= 1'b1;
      doneQ   <= 1'b0;
      failQ   <= 1'b0;
    end else begin
      state   <= stateNext;
      resetNQ <= (stateNext != ST_HOLD);
      doneQ   <= finishNow;
      if (state == ST_IDLE && start) failQ <= 1'b0;
      else if (finishNow) failQ <= finalFail;
    end
  end

  assign resetN = resetNQ;
  assign done   = doneQ;
  assign fail   = failQ;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fail) |-> done); // R7

  AST_PIN_HIGH_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> resetN); // R3

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETTLE && start) |=> (state == ST_SETTLE || state == ST_LINK)); // R9

endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import rst_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ   = 156250,
  parameter int unsigned HOLD_US   = 4000,
  parameter int unsigned SETTLE_US = 15000,
  parameter int unsigned LINK_US   = 200,
  parameter int unsigned MAX_TRIES = 3,
  parameter int unsigned LOL_W     = 4,
  parameter logic [LOL_W-1:0] IGNORE_MASK = 4'b1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             timerExpired,
  input  logic             pllSettled,
  input  logic [LOL_W-1:0] lossOfLock,
  output logic             resetN,
  output logic             done,
  output logic             fail
);

  localparam longint HOLD_CYC   = (longint'(CLK_KHZ) * HOLD_US + 999) / 1000;
  localparam longint SETTLE_CYC = (longint'(CLK_KHZ) * SETTLE_US + 999) / 1000;
  localparam longint LINK_CYC   = (longint'(CLK_KHZ) * LINK_US + 999) / 1000;
  localparam longint MAX_A      = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
  localparam longint MAX_CYC    = (MAX_A > LINK_CYC) ? MAX_A : LINK_CYC;
  localparam int unsigned CNT_W = $clog2(MAX_CYC + 1);

  seqStrobe_t strobe;
  logic timerZero, statusOk, lastTry;

  rst_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .timerZero (timerZero),
    .statusOk  (statusOk),
    .lastTry   (lastTry),
    .strobe    (strobe),
    .resetN    (resetN),
    .done      (done),
    .fail      (fail)
  );

  rst_seq_datapath #(
    .LOL_W       (LOL_W),
    .IGNORE_MASK (IGNORE_MASK),
    .MAX_TRIES   (MAX_TRIES),
    .CNT_W       (CNT_W),
    .HOLD_CYC    (HOLD_CYC),
    .SETTLE_CYC  (SETTLE_CYC),
    .LINK_CYC    (LINK_CYC)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .timerExpired (timerExpired),
    .pllSettled   (pllSettled),
    .lossOfLock   (lossOfLock),
    .timerZero    (timerZero),
    .statusOk     (statusOk),
    .lastTry      (lastTry)
  );

  // Length of the current low pulse on the pin
  logic [CNT_W:0] lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowRun <= '0;
    else if (!resetN) lowRun <= lowRun + 1'b1;
    else lowRun <= '0;
  end

  AST_HOLD_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetN) |-> lowRun == (CNT_W+1)'(HOLD_CYC)); // R2

  AST_HOLD_NOT_OVER: assert property (@(posedge clk) disable iff (!rstN)
    lowRun <= (CNT_W+1)'(HOLD_CYC)); // R2

endmodule

// File: tb/test_rst_sequencer.sv
module test_rst_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_KHZ    = 10;
  localparam int HOLD_US    = 4000;
  localparam int SETTLE_US  = 15000;
  localparam int LINK_US    = 200;
  localparam int TRIES      = 3;
  localparam logic [3:0] IGN = 4'b1000;
  localparam int H = (CLK_KHZ * HOLD_US + 999) / 1000;
  localparam int S = (CLK_KHZ * SETTLE_US + 999) / 1000;
  localparam int L = (CLK_KHZ * LINK_US + 999) / 1000;
  localparam int ATT = H + S + L + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic timerExpired = 1'b0;
  logic pllSettled = 1'b0;
  logic [3:0] lossOfLock = 4'b0;
  logic resetN, done, fail;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_sequencer #(
    .CLK_KHZ (CLK_KHZ), .HOLD_US (HOLD_US), .SETTLE_US (SETTLE_US),
    .LINK_US (LINK_US), .MAX_TRIES (TRIES), .LOL_W (4), .IGNORE_MASK (IGN)
  ) i_rst_sequencer (
    .clk (clk), .rstN (rstN), .start (start), .timerExpired (timerExpired),
    .pllSettled (pllSettled), .lossOfLock (lossOfLock),
    .resetN (resetN), .done (done), .fail (fail)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit attemptOk(input bit te, input bit pll, input logic [3:0] lol);
    return te && pll && ((lol & ~IGN) == 4'b0);
  endfunction

  // Runs one sequence; status per attempt given in arrays
  task automatic runSeq(input bit te[3], input bit pll[3], input logic [3:0] lol[3],
                        input bit pokeStart, input string tag);
    int n = 0, low = 0, idx = -1, expTries, gotFail;
    bit prevN = 1'b1, expFail = 1'b1;
    expTries = TRIES;
    for (int k = 0; k < TRIES; k++)
      if (expFail && attemptOk(te[k], pll[k], lol[k])) begin
        expFail = 1'b0;
        expTries = k + 1;
      end
    @(negedge clk);
    timerExpired = te[0]; pllSettled = pll[0]; lossOfLock = lol[0];
    start = 1'b1;
    forever begin
      @(negedge clk);
      start = 1'b0;
      n++;
      if (!resetN) low++;
      if (!resetN && prevN) begin
        idx++;
        if (idx < TRIES) begin
          timerExpired = te[idx]; pllSettled = pll[idx]; lossOfLock = lol[idx];
        end
      end
      prevN = resetN;
      if (pokeStart && n == H + 10) start = 1'b1;
      if (done || n > 5000) break;
    end
    gotFail = int'(fail);
    check(done == 1'b1, {tag, " R3 done seen"}, int'(done), 1);
    check(n == expTries * ATT + 1, {tag, " R3 R6 done timing"}, n, expTries * ATT + 1);
    check(low == expTries * H, {tag, " R2 R6 low cycles"}, low, expTries * H);
    check(gotFail == int'(expFail), {tag, " R4 R7 fail flag"}, gotFail, int'(expFail));
    @(negedge clk);
    check(done == 1'b0, {tag, " R8 done one cycle"}, int'(done), 0);
    check(fail == expFail, {tag, " R8 fail held"}, int'(fail), int'(expFail));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit te[3], pll[3];
    logic [3:0] lol[3];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(resetN == 1'b1, "R1 resetN idle", int'(resetN), 1);
    check(done == 1'b0, "R1 done idle", int'(done), 0);
    check(fail == 1'b0, "R1 fail idle", int'(fail), 0);

    // R4 clean pass
    te = '{1, 1, 1}; pll = '{1, 1, 1}; lol = '{4'b0, 4'b0, 4'b0};
    runSeq(te, pll, lol, 1'b0, "pass");
    // R5 only the ignored bit set
    lol = '{4'b1000, 4'b1000, 4'b1000};
    runSeq(te, pll, lol, 1'b0, "R5 ignored");
    // R7 monitored bit stuck on every attempt
    lol = '{4'b0001, 4'b0001, 4'b0001};
    runSeq(te, pll, lol, 1'b0, "R7 allfail");
    // R6 pass on second attempt
    te = '{0, 1, 1}; lol = '{4'b0, 4'b0, 4'b0};
    runSeq(te, pll, lol, 1'b0, "R6 second");
    // R6 pass on third attempt
    te = '{1, 1, 1}; pll = '{0, 1, 1}; lol = '{4'b0, 4'b0100, 4'b0};
    runSeq(te, pll, lol, 1'b0, "R6 third");
    // R9 start pulse during settle phase
    pll = '{1, 1, 1}; lol = '{4'b0010, 4'b0, 4'b0};
    runSeq(te, pll, lol, 1'b1, "R9 busy start");
    te = '{1, 1, 1}; pll = '{1, 1, 1}; lol = '{4'b0, 4'b0, 4'b0};
    runSeq(te, pll, lol, 1'b1, "R9 busy pass");

    // Random status patterns, R4
    for (int r = 0; r < 20; r++) begin
      for (int k = 0; k < 3; k++) begin
        te[k]  = ($urandom % 4) != 0;
        pll[k] = ($urandom % 4) != 0;
        lol[k] = (($urandom % 3) == 0) ? 4'($urandom) : 4'($urandom & 32'h8);
      end
      runSeq(te, pll, lol, ($urandom % 4) == 0, "R4 random");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule